// File: doc/BRIEF.md
# Galloping Read Address Sequencer

This block drives the read side of a galloping-pattern test on an n-word read-only memory. One word serves as the base. The block reads the base once. It then alternates between each higher-numbered word and the base, in rising order, until the top word has been paired with it. After that the base moves up by one, and the cycle repeats until every word has served as the base. This order exercises the change from every base address to every higher address, which a linear march does not.

A single-cycle `start` launches a pass. The block issues one read strobe per cycle with no gaps. The memory returns the word one cycle after the strobe, together with the expected programmed word for the same address. The block compares every bit and keeps the first failing address and data word. A read counter and a one-cycle `done` pulse let the surrounding test logic confirm the cycle budget and the outcome.

Top module: `galpat_seq`

## Requirements
- R1: While `rst` is high and afterwards until a start is accepted, `rd_en`, `done`, `busy` and `fail` are 0, and `fail_addr`, `fail_data` and `read_count` are 0.
- R2: A `start` seen high at a clock edge while `busy` is 0 is accepted. `rd_en` is then 1 with `rd_addr` = 0 in the following cycle, and it stays 1 on every cycle until all reads of the pass are issued.
- R3: For each base b, taken in the order 0, 1, …, n-1, the reads are: b, then the pairs (b+1, b), (b+2, b), …, (n-1, b). The final read of the pass is the single read of word n-1.
- R4: A pass issues exactly n·n reads. `read_count` is cleared on acceptance, rises by one per strobe, and holds n·n after the pass. `done` rises n·n+2 cycles after the start edge, which is inside the n·n+n cycle budget.
- R5: `rd_data` and `exp_data` are sampled in the cycle after each strobe. A difference in any single bit, or in all bits, sets `fail`.
- R6: `fail_addr` holds the address of the first mismatching read of the pass, and `fail_data` holds its returned word. Later mismatches do not change them.
- R7: `fail`, `fail_addr` and `fail_data` stay unchanged until the next accepted start, which clears them at its accepting edge.
- R8: `done` is high for exactly one cycle, the cycle after the last compare. A mismatch on that last compare is already visible on `fail` in the `done` cycle.
- R9: A `start` while `busy` is 1 is ignored: the address order, the gap-free strobes and the final count are unaffected.
- R10: `busy` is 1 from the cycle after acceptance through the cycle of the last compare, and 0 in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a pass; taken only when idle |
| rd_en | output | 1 | Read strobe to the memory |
| rd_addr | output | ADDR_W | Word address being read |
| rd_data | input | DATA_W | Word returned one cycle after the strobe |
| exp_data | input | DATA_W | Expected word, aligned with `rd_data` |
| busy | output | 1 | Pass in progress (reads or pending compare) |
| done | output | 1 | One-cycle end-of-pass pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_data | output | DATA_W | Returned word of the first mismatch |
| read_count | output | CNT_W | Strobes issued in the current or last pass |

## Verification
Two events share a cycle at the end of a pass: the compare of the final read and the raising of `done`. A pass is run with a corrupted word injected on read index n·n-1. The bench then checks that `fail`, `fail_addr` (= n-1) and `fail_data` are already correct in the `done` cycle, not one cycle later. A second clash is a `start` pulse in the middle of a pass, while `busy` is high. The bench judges it by comparing the whole address trace against the ping-pong order computed from the base and partner loops, and by checking the final `read_count`. The walking single-bit corruptions also give a sweep over bit positions and read positions.

// File: rtl/galpat_pkg.sv
package galpat_pkg;

    // Sequencer phase: which word the current cycle reads
    typedef enum logic [1:0] {
        PH_IDLE       = 2'd0,
        PH_BASE_FIRST = 2'd1,
        PH_OTHER      = 2'd2,
        PH_BASE_BACK  = 2'd3
    } phase_e;

    // Tag travelling alongside a read into the compare stage
    typedef struct packed {
        logic valid;
        logic last;
    } rd_tag_t;

    // Reads in one complete pass over n words
    function automatic longint pass_reads(input longint n);
        return n * n;
    endfunction

    // Cycles from the start edge to the done pulse
    function automatic longint pass_cycles(input longint n);
        return n * n + 2;
    endfunction

endpackage

// File: rtl/galpat_addr_gen.sv
module galpat_addr_gen
    import galpat_pkg::*;
#(
    parameter int N_WORDS = 1024,
    parameter int ADDR_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              last_rd,
    output logic              active
);

    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(N_WORDS - 1);

    phase_e            phase;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] other;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            base  <= '0;
            other <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (launch) begin
                        base  <= '0;
                        other <= '0;
                        phase <= PH_BASE_FIRST;
                    end
                end
                PH_BASE_FIRST: begin
                    if (base == TOP) begin
                        phase <= PH_IDLE;
                    end else begin
                        other <= base + 1'b1;
                        phase <= PH_OTHER;
                    end
                end
                PH_OTHER: begin
                    phase <= PH_BASE_BACK;
                end
                PH_BASE_BACK: begin
                    if (other == TOP) begin
                        base  <= base + 1'b1;
                        phase <= PH_BASE_FIRST;
                    end else begin
                        other <= other + 1'b1;
                        phase <= PH_OTHER;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        active  = (phase != PH_IDLE);
        rd_en   = active;
        rd_addr = (phase == PH_OTHER) ? other : base;
        last_rd = (phase == PH_BASE_FIRST) && (base == TOP);
    end

    AST_PARTNER_ABOVE_BASE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OTHER) |-> (other > base)); // R3

    AST_RETURN_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && phase == PH_OTHER) |=> (rd_en && rd_addr == $past(base))); // R3

    AST_BASE_RISES: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> (base >= $past(base))); // R3

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr <= TOP)); // R3

endmodule

// File: rtl/galpat_read_cnt.sv
module galpat_read_cnt
    import galpat_pkg::*;
#(
    parameter int N_WORDS = 1024,
    parameter int CNT_W   = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(pass_reads(N_WORDS));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= LIMIT); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clear) |=> (count != '0)); // R4

endmodule

// File: rtl/galpat_compare.sv
module galpat_compare
    import galpat_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              last_rd,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] exp_data,
    output logic              pending,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_data
);

    rd_tag_t           tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic              mismatch;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            addr_q <= '0;
            done   <= 1'b0;
        end else begin
            tag_q.valid <= rd_en;
            tag_q.last  <= rd_en && last_rd;
            addr_q      <= rd_addr;
            done        <= tag_q.valid && tag_q.last;
        end
    end

    always_comb begin
        mismatch = tag_q.valid && (rd_data != exp_data);
        pending  = tag_q.valid;
    end

    always_ff @(posedge clk) begin
        if (rst || launch) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_data <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr_q;
            fail_data <= rd_data;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (tag_q.valid && rd_data != exp_data && !launch) |=> fail); // R5

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail && !launch) |=> fail); // R7

    AST_FIRST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (fail && !launch) |=> ($stable(fail_addr) && $stable(fail_data))); // R6

endmodule

// File: rtl/galpat_seq.sv
module galpat_seq
    import galpat_pkg::*;
#(
    parameter int N_WORDS = 1024,
    parameter int DATA_W  = 8,
    localparam int ADDR_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int CNT_W  = $clog2(N_WORDS * N_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] exp_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_data,
    output logic [CNT_W-1:0]  read_count
);

    logic launch;
    logic active;
    logic pending;
    logic last_rd;

    always_comb begin
        busy   = active || pending;
        launch = start && !busy;
    end

    galpat_addr_gen #(
        .N_WORDS (N_WORDS),
        .ADDR_W  (ADDR_W)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .last_rd (last_rd),
        .active  (active)
    );

    galpat_read_cnt #(
        .N_WORDS (N_WORDS),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (launch),
        .inc   (rd_en),
        .count (read_count)
    );

    galpat_compare #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .last_rd   (last_rd),
        .rd_data   (rd_data),
        .exp_data  (exp_data),
        .pending   (pending),
        .done      (done),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_data (fail_data)
    );

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (read_count >= $past(read_count))); // R9

    AST_LAUNCH_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        launch |=> (rd_en && rd_addr == '0 && busy)); // R2

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

endmodule

// File: tb/tb_galpat_seq.sv
`timescale 1ns/1ps
module tb_galpat_seq;

    localparam int N      = 8;
    localparam int DW     = 8;
    localparam int AW     = 3;
    localparam int CW     = 7;
    localparam int NREADS = N * N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] exp_data;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_data;
    logic [CW-1:0] read_count;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    galpat_seq #(.N_WORDS(N), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .start(start),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .exp_data(exp_data),
        .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_data(fail_data),
        .read_count(read_count)
    );

    function automatic logic [DW-1:0] rom(input int a);
        return DW'((a * 37 + 5) & 8'hFF);
    endfunction

    // Memory model: one-cycle read, corruption injected by read index
    logic          m_clr = 1'b0;
    int            m_idx = 0;
    int            m_k1 = -1;
    int            m_k2 = -1;
    logic [DW-1:0] m_mask = '0;

    always @(posedge clk) begin
        if (m_clr) begin
            m_idx <= 0;
        end else if (rd_en) begin
            m_idx    <= m_idx + 1;
            rd_data  <= rom(int'(rd_addr)) ^ ((m_idx == m_k1 || m_idx == m_k2) ? m_mask : '0);
            exp_data <= rom(int'(rd_addr));
        end
    end

    // Expected address order computed from the base / partner loops
    int exp_seq [NREADS];
    initial begin
        int p;
        p = 0;
        for (int b = 0; b < N; b++) begin
            exp_seq[p] = b; p++;
            for (int w = b + 1; w < N; w++) begin
                exp_seq[p] = w; p++;
                exp_seq[p] = b; p++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_pass(input int k1, input int k2, input logic [DW-1:0] mask,
                            input int poke);
        int  idx = 0;
        int  cyc = 0;
        int  seq_bad = 0;
        int  first_bad = -1;
        int  gap = 0;
        int  busy_bad = 0;
        bit  exp_fail;
        m_k1 = k1; m_k2 = k2; m_mask = mask;
        m_clr = 1'b1;
        @(negedge clk);
        m_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk(fail == 1'b0, "R7", "fail cleared by accepted start", fail, 0);
        chk(read_count == 0, "R4", "count cleared at start", read_count, 0);
        while (!done && cyc <= NREADS + 20) begin
            if (rd_en) begin
                if (idx < NREADS && int'(rd_addr) != exp_seq[idx]) begin
                    seq_bad++;
                    if (first_bad < 0) first_bad = idx;
                end
                idx++;
            end else if (idx < NREADS) begin
                gap++;
            end
            if (!busy) busy_bad++;
            start = (idx == poke);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        exp_fail = (k1 >= 0 && k1 < NREADS);
        chk(done == 1'b1, "R8", "done reached (watchdog)", done, 1);
        chk(seq_bad == 0, "R3", "ping-pong address order mismatches", seq_bad, 0);
        if (first_bad >= 0)
            chk(0, "R3", "first wrong read index", first_bad, exp_seq[first_bad]);
        chk(gap == 0, "R2", "missing strobes inside pass", gap, 0);
        chk(idx == NREADS, "R4", "strobes issued", idx, NREADS);
        chk(read_count == NREADS, "R4", "read_count at done", read_count, NREADS);
        chk(cyc == NREADS + 2, "R4", "start-to-done cycles", cyc, NREADS + 2);
        chk(cyc <= NREADS + N, "R4", "cycle budget", cyc, NREADS + N);
        chk(busy_bad == 0, "R10", "busy low during pass", busy_bad, 0);
        chk(busy == 1'b0, "R10", "busy at done", busy, 0);
        chk(fail == exp_fail, "R5", "fail flag at done cycle (R8)", fail, exp_fail);
        if (exp_fail) begin
            chk(int'(fail_addr) == exp_seq[k1], "R6", "first fail address",
                fail_addr, exp_seq[k1]);
            chk(fail_data == (rom(exp_seq[k1]) ^ mask), "R6", "first fail data",
                fail_data, rom(exp_seq[k1]) ^ mask);
        end
        @(negedge clk);
        chk(done == 1'b0, "R8", "done is single cycle", done, 0);
        chk(fail == exp_fail, "R7", "fail held after pass", fail, exp_fail);
        chk(read_count == NREADS, "R4", "read_count holds", read_count, NREADS);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!rd_en && !busy && !done && !fail, "R1", "control outputs in reset",
            {rd_en, busy, done, fail}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!rd_en && !busy && !done && !fail, "R1", "control outputs idle",
            {rd_en, busy, done, fail}, 0);
        chk(read_count == 0 && fail_addr == 0 && fail_data == 0, "R1",
            "capture and count idle", read_count, 0);

        // Clean pass
        run_pass(-1, -1, '0, -1);
        // Walking single-bit corruptions across read positions; bit 7 hits the last read (R8)
        for (int bt = 0; bt < DW; bt++)
            run_pass(bt * 9, bt * 9 + 3, DW'(1) << bt, -1);
        // All bits corrupted on two consecutive reads; first one kept (R6)
        run_pass(30, 31, 8'hFF, -1);
        // Clean pass after a failing one (R7)
        run_pass(-1, -1, '0, -1);
        // Start pulses while busy are ignored (R9)
        run_pass(-1, -1, '0, 20);
        run_pass(5, -1, 8'h10, NREADS - 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule